// File: doc/BRIEF.md
# Sliced VBI Byte FIFO with Interrupt Register Bank

The block buffers packets of sliced vertical-blanking data. A producer pushes bytes through a one-cycle write strobe. A host drains them through a small register window on a simple read/write bus, and each read of the data register pops one byte. The FIFO holds 512 bytes. Its fill level is also measured in 16-bit words, which is the byte count divided by two and rounded down. A programmable 8-bit threshold raises an interrupt source once the word count is strictly greater than the threshold.

The block also holds eight interrupt sources, each with a raw flag, a mask bit and a write-one-to-clear bit. Bit 7 is the FIFO-threshold source. Bits 6..0 are set by external event pulses from the slicers. The host reads the status register and gets the raw flags ANDed with the mask. The active-high interrupt pin is the OR of those masked bits. A control write empties the FIFO. Writes that arrive while the FIFO is full are dropped and set a sticky overflow flag.

Register map (3-bit address): 0 data (read pops), 1 byte count bits 7..0, 2 byte count bits 9..8 in bits 1..0, 3 threshold, 4 control, 5 status, 6 mask, 7 clear. Read data appears on `hb_rdata` on the clock edge that accepts the read, and it holds until the next read.

Top module: `vbi_fifo_irq`

## Requirements
- R1: After reset the FIFO is empty, both count registers read 00h, the threshold reads 80h, mask and status read 00h, `irq_o` is low and `hb_rdata` is 00h.
- R2: Bytes come out of the data register (address 0) in the order they were pushed. The byte count reads back at address 1 (bits 7..0) and address 2 (bits 1..0 hold count bits 9..8).
- R3: Exactly 512 bytes are accepted. A push while the FIFO is full is dropped, leaves the count unchanged and sets the overflow flag, which reads as bit 1 of control (address 4) and stays set.
- R4: A data read from an empty FIFO returns 00h and leaves the count at 0.
- R5: Writing control (address 4) with bit 0 set empties the FIFO and clears the overflow flag. A push in the same cycle is discarded. Control bit 0 reads as 0.
- R6: Raw bit 7 is set whenever floor(bytes/2) is greater than the threshold (address 3). It is not set when the two are equal.
- R7: A pulse on `ext_evt[i]` sets raw bit i, for i = 0..6. Bit 6 is teletext, 5 is WSS/CGMS, 4 is VPS, 3 is VITC, 2 is closed-caption field 2, 1 is closed-caption field 1 and 0 is the line event. Raw flags are sticky.
- R8: Status (address 5) reads the raw flags ANDed with the mask (address 6). The mask is read/write.
- R9: Writing clear (address 7) clears each raw bit written as 1 and leaves bits written as 0 unchanged. An event in the same cycle as its clear leaves the bit set. Clear reads as 00h.
- R10: `irq_o` is high exactly when some raw bit and its mask bit are both 1.
- R11: A read of an address that does not pop (addresses 1..7) leaves the FIFO contents and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Producer byte push strobe |
| wr_data | input | 8 | Producer byte |
| ext_evt | input | 7 | One-cycle event pulses for interrupt sources 6..0 |
| hb_sel | input | 1 | Host access strobe |
| hb_wr | input | 1 | Host access is a write when high |
| hb_addr | input | 3 | Host register address |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Host read data, registered |
| irq_o | output | 1 | Active-high interrupt, OR of masked status |

## Verification
The FIFO is run with short interleaved push and pop runs, which expose ordering and count errors. It is also filled to its full 512 bytes and one beyond, which separates correct full detection and overflow from an off-by-one depth. The threshold is tried at word counts equal to it and one above it, both at a small programmed value and at the reset value, which tells a strict comparison from a greater-or-equal one and a word count from a byte count. The interrupt sources are driven with mixed event patterns under partial and full masks, clears with mixed one and zero bits, and an event and a clear in the same cycle. Together these separate the masking, the selective clear and the event-wins rule.

// File: rtl/vfq_pkg.sv
package vfq_pkg;

  typedef enum logic [2:0] {
    RA_DATA   = 3'd0,
    RA_CNT_LO = 3'd1,
    RA_CNT_HI = 3'd2,
    RA_THRESH = 3'd3,
    RA_CTRL   = 3'd4,
    RA_STATUS = 3'd5,
    RA_MASK   = 3'd6,
    RA_CLEAR  = 3'd7
  } reg_addr_e;

  localparam int CTRL_FLUSH_BIT = 0;
  localparam int CTRL_OVF_BIT   = 1;

  // Byte count to 16-bit word count (floor).
  function automatic logic [15:0] words_of(input logic [15:0] bytes);
    return bytes >> 1;
  endfunction

  // Strict comparison of the word count against the threshold.
  function automatic logic thr_exceeded(input logic [15:0] words, input logic [7:0] thr);
    return words > {8'd0, thr};
  endfunction

  // One raw flag: a clear drops it, an event sets it, and the event wins.
  function automatic logic next_flag(input logic cur, input logic evt, input logic clr);
    return (cur & ~clr) | evt;
  endfunction

endpackage

// File: rtl/vfq_byte_fifo.sv
module vfq_byte_fifo #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          push_drop,
  output logic          pop_ok,
  output logic          ovf
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, empty;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push & ~full & ~flush;
  assign push_drop = push & full & ~flush;
  assign pop_ok    = pop & ~empty & ~flush;
  assign dout      = empty ? '0 : mem[rd_ptr];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_drop) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/vfq_irq_bank.sv
module vfq_irq_bank
  import vfq_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_bits,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] status,
  output logic            irq
);

  logic [NSRC-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw[i]  <= 1'b0;
        mask[i] <= 1'b0;
      end else begin
        raw[i] <= next_flag(raw[i], evt[i], clr_eff[i]);
        if (mask_we) mask[i] <= mask_wdata[i];
      end
    end
  end

  assign status = raw & mask;
  assign irq    = |status;

endmodule

// File: rtl/vfq_hostif.sv
module vfq_hostif
  import vfq_pkg::*;
#(
  parameter int        CW        = 10,
  parameter logic [7:0] THR_RESET = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hb_sel,
  input  logic          hb_wr,
  input  logic [2:0]    hb_addr,
  input  logic [7:0]    hb_wdata,
  output logic [7:0]    hb_rdata,
  input  logic [7:0]    fifo_dout,
  input  logic [CW-1:0] fifo_cnt,
  input  logic          ovf,
  input  logic [7:0]    status,
  input  logic [7:0]    mask,
  output logic          pop_req,
  output logic          flush_req,
  output logic          mask_we,
  output logic          clr_we,
  output logic [7:0]    thresh
);

  logic       rd_acc, wr_acc;
  logic [7:0] rd_mux;
  logic [15:0] cnt16;

  assign rd_acc    = hb_sel & ~hb_wr;
  assign wr_acc    = hb_sel & hb_wr;
  assign pop_req   = rd_acc & (hb_addr == RA_DATA);
  assign flush_req = wr_acc & (hb_addr == RA_CTRL) & hb_wdata[CTRL_FLUSH_BIT];
  assign mask_we   = wr_acc & (hb_addr == RA_MASK);
  assign clr_we    = wr_acc & (hb_addr == RA_CLEAR);
  assign cnt16     = 16'(fifo_cnt);

  always_comb begin
    rd_mux = 8'h00;
    case (reg_addr_e'(hb_addr))
      RA_DATA:   rd_mux = fifo_dout;
      RA_CNT_LO: rd_mux = cnt16[7:0];
      RA_CNT_HI: rd_mux = cnt16[15:8];
      RA_THRESH: rd_mux = thresh;
      RA_CTRL:   rd_mux = 8'(ovf) << CTRL_OVF_BIT;
      RA_STATUS: rd_mux = status;
      RA_MASK:   rd_mux = mask;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_rdata <= 8'h00;
      thresh   <= THR_RESET;
    end else begin
      if (rd_acc) hb_rdata <= rd_mux;
      if (wr_acc && hb_addr == RA_THRESH) thresh <= hb_wdata;
    end
  end

endmodule

// File: rtl/vbi_fifo_irq.sv
module vbi_fifo_irq
  import vfq_pkg::*;
#(
  parameter int         DEPTH     = 512,
  parameter logic [7:0] THR_RESET = 8'h80,
  localparam int        CW        = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [6:0] ext_evt,
  input  logic       hb_sel,
  input  logic       hb_wr,
  input  logic [2:0] hb_addr,
  input  logic [7:0] hb_wdata,
  output logic [7:0] hb_rdata,
  output logic       irq_o
);

  // Named internal events, visible to the bound checker.
  logic [CW-1:0] fifo_cnt;
  logic [7:0]    fifo_dout;
  logic          push_ok, push_drop, pop_ok, ovf;
  logic          pop_req, flush_req, mask_we, clr_we;
  logic [7:0]    thresh_q, raw_q, mask_q, status_q;
  logic          thr_hit;

  assign thr_hit = thr_exceeded(words_of(16'(fifo_cnt)), thresh_q);

  vfq_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk, .rst_n,
    .flush     (flush_req),
    .push      (wr_en),
    .din       (wr_data),
    .pop       (pop_req),
    .dout      (fifo_dout),
    .count     (fifo_cnt),
    .push_ok   (push_ok),
    .push_drop (push_drop),
    .pop_ok    (pop_ok),
    .ovf       (ovf)
  );

  vfq_irq_bank #(.NSRC(8)) u_irq (
    .clk, .rst_n,
    .evt        ({thr_hit, ext_evt}),
    .clr_we     (clr_we),
    .clr_bits   (hb_wdata),
    .mask_we    (mask_we),
    .mask_wdata (hb_wdata),
    .raw        (raw_q),
    .mask       (mask_q),
    .status     (status_q),
    .irq        (irq_o)
  );

  vfq_hostif #(.CW(CW), .THR_RESET(THR_RESET)) u_host (
    .clk, .rst_n,
    .hb_sel, .hb_wr, .hb_addr, .hb_wdata,
    .hb_rdata  (hb_rdata),
    .fifo_dout (fifo_dout),
    .fifo_cnt  (fifo_cnt),
    .ovf       (ovf),
    .status    (status_q),
    .mask      (mask_q),
    .pop_req   (pop_req),
    .flush_req (flush_req),
    .mask_we   (mask_we),
    .clr_we    (clr_we),
    .thresh    (thresh_q)
  );

endmodule

// File: rtl/vfq_chk.sv
module vfq_chk #(
  parameter int DEPTH = 512,
  parameter int CW    = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] fifo_cnt,
  input logic          push_drop,
  input logic          ovf,
  input logic          flush_req,
  input logic          pop_req,
  input logic [7:0]    hb_rdata,
  input logic          thr_hit,
  input logic [6:0]    ext_evt,
  input logic [7:0]    raw_q,
  input logic [7:0]    mask_q,
  input logic          irq_o
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH)); // R3
  AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovf); // R3
  AST_DROP_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_req) |=> $stable(fifo_cnt)); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (fifo_cnt == '0 && !ovf)); // R5
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && fifo_cnt == '0) |=> (hb_rdata == 8'h00)); // R4
  AST_THR_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hit |=> raw_q[7]); // R6
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt[0] |=> raw_q[0]); // R9
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |-> !irq_o); // R10

endmodule

bind vbi_fifo_irq vfq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fifo_cnt  (fifo_cnt),
  .push_drop (push_drop),
  .ovf       (ovf),
  .flush_req (flush_req),
  .pop_req   (pop_req),
  .hb_rdata  (hb_rdata),
  .thr_hit   (thr_hit),
  .ext_evt   (ext_evt),
  .raw_q     (raw_q),
  .mask_q    (mask_q),
  .irq_o     (irq_o)
);

// File: tb/sim_vbi_fifo_irq.sv
module sim_vbi_fifo_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [6:0] ext_evt = 7'h00;
  logic       hb_sel = 1'b0;
  logic       hb_wr = 1'b0;
  logic [2:0] hb_addr = 3'd0;
  logic [7:0] hb_wdata = 8'h00;
  logic [7:0] hb_rdata;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  vbi_fifo_irq u0 (.*);

  localparam logic [2:0] A_DATA = 3'd0, A_CLO = 3'd1, A_CHI = 3'd2, A_THR = 3'd3,
                         A_CTRL = 3'd4, A_STAT = 3'd5, A_MASK = 3'd6, A_CLR = 3'd7;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PUSH = 2'd2, OP_EVT = 2'd3;

  // {req[3:0], op[1:0], addr[2:0], data[7:0], exp[7:0]}
  localparam int NV = 34;
  localparam logic [24:0] VECS [NV] = '{
    {4'd1,  OP_RD,   A_THR,  8'h00, 8'h80},  // R1 threshold reset value
    {4'd1,  OP_RD,   A_MASK, 8'h00, 8'h00},  // R1
    {4'd1,  OP_RD,   A_STAT, 8'h00, 8'h00},  // R1
    {4'd1,  OP_RD,   A_CLO,  8'h00, 8'h00},  // R1
    {4'd2,  OP_PUSH, A_DATA, 8'hA1, 8'h00},  // R2
    {4'd2,  OP_PUSH, A_DATA, 8'hB2, 8'h00},
    {4'd2,  OP_PUSH, A_DATA, 8'hC3, 8'h00},
    {4'd2,  OP_RD,   A_CLO,  8'h00, 8'h03},  // R2 count
    {4'd11, OP_RD,   A_CHI,  8'h00, 8'h00},  // R11 non-pop read
    {4'd11, OP_RD,   A_CLO,  8'h00, 8'h03},  // R11 count unchanged
    {4'd2,  OP_RD,   A_DATA, 8'h00, 8'hA1},  // R2 order
    {4'd2,  OP_RD,   A_DATA, 8'h00, 8'hB2},
    {4'd2,  OP_PUSH, A_DATA, 8'hD4, 8'h00},
    {4'd2,  OP_RD,   A_DATA, 8'h00, 8'hC3},
    {4'd2,  OP_RD,   A_DATA, 8'h00, 8'hD4},
    {4'd4,  OP_RD,   A_DATA, 8'h00, 8'h00},  // R4 empty read
    {4'd4,  OP_RD,   A_CLO,  8'h00, 8'h00},  // R4
    {4'd8,  OP_WR,   A_MASK, 8'h0F, 8'h00},  // R8
    {4'd8,  OP_RD,   A_MASK, 8'h00, 8'h0F},  // R8 mask readback
    {4'd7,  OP_EVT,  A_DATA, 8'h05, 8'h00},  // R7 sources 2 and 0
    {4'd8,  OP_RD,   A_STAT, 8'h00, 8'h05},  // R8
    {4'd7,  OP_EVT,  A_DATA, 8'h30, 8'h00},  // R7 sources 5 and 4
    {4'd8,  OP_RD,   A_STAT, 8'h00, 8'h05},  // R8 masked off
    {4'd8,  OP_WR,   A_MASK, 8'hFF, 8'h00},
    {4'd7,  OP_RD,   A_STAT, 8'h00, 8'h35},  // R7 sticky raw
    {4'd9,  OP_WR,   A_CLR,  8'h14, 8'h00},  // R9 clear bits 4,2
    {4'd9,  OP_RD,   A_STAT, 8'h00, 8'h21},  // R9
    {4'd9,  OP_WR,   A_CLR,  8'h00, 8'h00},  // R9 zeros ignored
    {4'd9,  OP_RD,   A_STAT, 8'h00, 8'h21},  // R9
    {4'd9,  OP_RD,   A_CLR,  8'h00, 8'h00},  // R9 clear reads 0
    {4'd7,  OP_EVT,  A_DATA, 8'h4A, 8'h00},  // R7 sources 6,3,1
    {4'd7,  OP_RD,   A_STAT, 8'h00, 8'h6B},  // R7
    {4'd9,  OP_WR,   A_CLR,  8'hFF, 8'h00},
    {4'd9,  OP_RD,   A_STAT, 8'h00, 8'h00}   // R9
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_sel = 1'b0; hb_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b0; hb_addr = a;
    @(negedge clk);
    hb_sel = 1'b0;
    d = hb_rdata;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [6:0] e);
    @(negedge clk);
    ext_evt = e;
    @(negedge clk);
    ext_evt = 7'h00;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    check("R1 rdata", hb_rdata, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VECS[i];
      case (v[20:19])
        OP_WR:   host_wr(v[18:16], v[15:8]);
        OP_PUSH: push(v[15:8]);
        OP_EVT:  pulse_evt(v[14:8]);
        default: begin
          host_rd(v[18:16], rv);
          check($sformatf("R%0d table step %0d", v[24:21], i), rv, v[7:0]);
        end
      endcase
    end

    // R10: pin follows masked status
    host_wr(A_MASK, 8'h02);
    pulse_evt(7'h01);
    check("R10 irq with unmasked source only", {7'd0, irq_o}, 8'h00);
    pulse_evt(7'h02);
    check("R10 irq on masked-in source", {7'd0, irq_o}, 8'h01);
    host_wr(A_MASK, 8'h00);
    check("R10 irq after mask off", {7'd0, irq_o}, 8'h00);

    // R9: event and clear in the same cycle, event wins
    host_wr(A_MASK, 8'hFF);
    host_wr(A_CLR, 8'hFF);
    @(negedge clk);
    ext_evt = 7'h08; hb_sel = 1'b1; hb_wr = 1'b1; hb_addr = A_CLR; hb_wdata = 8'h08;
    @(negedge clk);
    ext_evt = 7'h00; hb_sel = 1'b0; hb_wr = 1'b0;
    host_rd(A_STAT, rv);
    check("R9 event beats same-cycle clear", rv, 8'h08);
    host_wr(A_CLR, 8'h08);
    host_rd(A_STAT, rv);
    check("R9 later clear", rv, 8'h00);

    // R6: strict threshold at a small programmed value
    host_wr(A_THR, 8'h02);
    host_wr(A_MASK, 8'h80);
    for (int i = 0; i < 5; i++) push(8'(i));
    @(negedge clk);
    host_rd(A_STAT, rv);
    check("R6 words equal threshold", rv, 8'h00);
    push(8'h55);
    @(negedge clk);
    host_rd(A_STAT, rv);
    check("R6 words above threshold", rv, 8'h80);

    // R5: flush empties
    host_wr(A_CTRL, 8'h01);
    host_rd(A_CLO, rv);
    check("R5 count after flush", rv, 8'h00);
    host_rd(A_CTRL, rv);
    check("R5 control after flush", rv, 8'h00);
    host_wr(A_THR, 8'h80);
    host_wr(A_CLR, 8'hFF);
    host_rd(A_STAT, rv);
    check("R6 cleared once below threshold", rv, 8'h00);

    // R6 at default threshold, then R3 full and overflow
    @(negedge clk);
    wr_en = 1'b1;
    for (int i = 0; i < 257; i++) begin
      wr_data = 8'(i) ^ 8'h5A;
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);
    host_rd(A_STAT, rv);
    check("R6 default threshold, 128 words", rv, 8'h00);
    push(8'(257) ^ 8'h5A);
    @(negedge clk);
    host_rd(A_STAT, rv);
    check("R6 default threshold, 129 words", rv, 8'h80);
    check("R10 irq from threshold", {7'd0, irq_o}, 8'h01);
    @(negedge clk);
    wr_en = 1'b1;
    for (int i = 258; i < 512; i++) begin
      wr_data = 8'(i) ^ 8'h5A;
      @(negedge clk);
    end
    wr_en = 1'b0;
    host_rd(A_CTRL, rv);
    check("R3 no overflow at exactly full", rv, 8'h00);
    push(8'hEE);
    host_rd(A_CHI, rv);
    check("R3 count hi when full", rv, 8'h02);
    host_rd(A_CLO, rv);
    check("R3 count lo when full", rv, 8'h00);
    host_rd(A_CTRL, rv);
    check("R3 overflow flag", rv, 8'h02);
    begin
      int errs;
      errs = 0;
      for (int i = 0; i < 512; i++) begin
        host_rd(A_DATA, rv);
        if (rv !== (8'(i) ^ 8'h5A)) begin
          if (errs == 0) check($sformatf("R2 full drain byte %0d", i), rv, 8'(i) ^ 8'h5A);
          errs++;
        end
      end
      if (errs == 0) check("R2 full drain order", 8'h00, 8'h00);
    end
    host_rd(A_DATA, rv);
    check("R4 read after drain", rv, 8'h00);
    host_rd(A_CTRL, rv);
    check("R3 overflow sticky after drain", rv, 8'h02);

    // R5: push in the flush cycle is discarded
    push(8'h11);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b1; hb_addr = A_CTRL; hb_wdata = 8'h01;
    wr_en = 1'b1; wr_data = 8'h22;
    @(negedge clk);
    hb_sel = 1'b0; hb_wr = 1'b0; wr_en = 1'b0;
    host_rd(A_CLO, rv);
    check("R5 push during flush dropped", rv, 8'h00);
    host_rd(A_CTRL, rv);
    check("R5 overflow cleared by flush", rv, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule